// File: doc/BRIEF.md
# Per-Thread Memory Request Slot Tracker

This block keeps a small table of in-flight request slots for a load/store unit that is shared by several hardware threads. Each slot records a valid bit, the owning thread, a sequence number, an instruction tag, a schedule index and a command. It also carries four status flags: pending, complete, stalled and squashed. The pipeline allocates a slot when an instruction enters the unit. It finds the slot again by tag and schedule index, and it marks the slot as issued, stalled, faulted, answered or finished through slot-numbered strobes.

Two mechanisms act on a whole thread. The first is a selective squash, which removes younger work of a single thread. The second is a per-thread lock. A translation fault sets the lock, and it refuses new allocations for that thread until a trap or a squash that reaches back far enough releases it. A slot that is squashed while its memory access is still outstanding stays in the table until the response returns. That response is then absorbed without completing the slot.

Top module: `memreq_slot_table`

## Requirements
- R1: An allocation request from a thread whose lock is set is refused. `alloc_blocked` is high and `alloc_gnt` is low.
- R2: A fault strobe on a valid slot sets the lock of that slot's thread and records the slot's sequence number. It also sets the slot's complete flag.
- R3: A squash for thread T with boundary S acts on every valid, not yet squashed slot of T whose sequence number is greater than S. A slot with no access pending is freed. A slot with an access pending is marked squashed. Slots of other threads, slots with sequence ≤ S and slots already squashed are left unchanged.
- R4: A squash for thread T releases T's lock when the recorded blocking sequence number is greater than the boundary. Otherwise the lock is kept.
- R5: When `sq_stall` is high, the boundary is S+1 instead of S, so a slot with sequence S+1 survives.
- R6: A response to a pending, squashed slot clears pending and frees the slot. A response to a pending slot that is not squashed clears pending and stalled, and sets complete.
- R7: A trap strobe clears the lock of the named thread, unless a fault for that thread arrives in the same cycle.
- R8: A lookup hits only a valid slot whose tag and schedule index both match. It reports that slot's number and its flags (lowest slot number if several match).
- R9: Allocation takes the lowest-numbered free slot, presented combinationally on `alloc_slot`. With no free slot, `alloc_busy` is high and nothing is granted.
- R10: A squash and an allocation in the same cycle are resolved squash first. Slots freed and locks released by the squash are available to that allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocation request |
| alloc_tid | input | TW | Requesting thread |
| alloc_seq | input | SEQW | Sequence number of the instruction |
| alloc_tag | input | TAGW | Instruction tag |
| alloc_idx | input | IDXW | Schedule index |
| alloc_cmd | input | CMDW | Command code (stored, returned on lookup) |
| alloc_gnt | output | 1 | Allocation granted this cycle |
| alloc_slot | output | SW | Slot given to the allocation |
| alloc_busy | output | 1 | No free slot |
| alloc_blocked | output | 1 | Thread is locked |
| find_tag | input | TAGW | Lookup tag |
| find_idx | input | IDXW | Lookup schedule index |
| find_hit | output | 1 | Lookup matched |
| find_slot | output | SW | Matching slot |
| find_pend | output | 1 | Pending flag of match |
| find_cmpl | output | 1 | Complete flag of match |
| find_stall | output | 1 | Stalled flag of match |
| find_sq | output | 1 | Squashed flag of match |
| find_cmd | output | CMDW | Command of match |
| issue_vld | input | 1 | Access sent for a slot |
| issue_slot | input | SW | Slot issued |
| stall_vld | input | 1 | Slot waits on memory |
| stall_slot | input | SW | Slot stalled |
| fault_vld | input | 1 | Translation fault on a slot |
| fault_slot | input | SW | Faulting slot |
| resp_vld | input | 1 | Memory response |
| resp_slot | input | SW | Slot answered |
| free_vld | input | 1 | Slot finished, release it |
| free_slot | input | SW | Slot released |
| sq_vld | input | 1 | Squash broadcast |
| sq_tid | input | TW | Squashed thread |
| sq_seq | input | SEQW | Squash sequence S |
| sq_stall | input | 1 | Squash raised by a memory stall (boundary S+1) |
| trap_vld | input | 1 | Trap taken |
| trap_tid | input | TW | Thread of the trap |
| blk_o | output | NTHR | Per-thread lock flags |

## Verification
The squash is tried on a mixed table: two threads, sequence numbers on both sides of the boundary, and one pending slot. This separates freeing from marking, shows that the thread is selected, and shows that the sequence comparison is strict. A second, older squash over an already-squashed pending slot shows that such a slot is skipped. A stall-flavoured squash is set beside a plain one on the same sequences so that the S+1 boundary can be told apart. Lock release is tried with a boundary above and below the blocking sequence. A full table is squashed and allocated in the same cycle to show the squash-first order. Lookups that differ only in schedule index confirm the two-field match.

// File: rtl/memreq_slot_table.sv
module memreq_slot_table #(
  parameter int NSLOT = 4,
  parameter int NTHR  = 2,
  parameter int SEQW  = 16,
  parameter int TAGW  = 8,
  parameter int IDXW  = 4,
  parameter int CMDW  = 3,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_req,
  input  logic [TW-1:0]   alloc_tid,
  input  logic [SEQW-1:0] alloc_seq,
  input  logic [TAGW-1:0] alloc_tag,
  input  logic [IDXW-1:0] alloc_idx,
  input  logic [CMDW-1:0] alloc_cmd,
  output logic            alloc_gnt,
  output logic [SW-1:0]   alloc_slot,
  output logic            alloc_busy,
  output logic            alloc_blocked,
  input  logic [TAGW-1:0] find_tag,
  input  logic [IDXW-1:0] find_idx,
  output logic            find_hit,
  output logic [SW-1:0]   find_slot,
  output logic            find_pend,
  output logic            find_cmpl,
  output logic            find_stall,
  output logic            find_sq,
  output logic [CMDW-1:0] find_cmd,
  input  logic            issue_vld,
  input  logic [SW-1:0]   issue_slot,
  input  logic            stall_vld,
  input  logic [SW-1:0]   stall_slot,
  input  logic            fault_vld,
  input  logic [SW-1:0]   fault_slot,
  input  logic            resp_vld,
  input  logic [SW-1:0]   resp_slot,
  input  logic            free_vld,
  input  logic [SW-1:0]   free_slot,
  input  logic            sq_vld,
  input  logic [TW-1:0]   sq_tid,
  input  logic [SEQW-1:0] sq_seq,
  input  logic            sq_stall,
  input  logic            trap_vld,
  input  logic [TW-1:0]   trap_tid,
  output logic [NTHR-1:0] blk_o
);

  logic [NSLOT-1:0] v_q, pend_q, cmpl_q, stl_q, sq_q;
  logic [TW-1:0]    tid_q [NSLOT];
  logic [SEQW-1:0]  seq_q [NSLOT];
  logic [TAGW-1:0]  tag_q [NSLOT];
  logic [IDXW-1:0]  idx_q [NSLOT];
  logic [CMDW-1:0]  cmd_q [NSLOT];

  logic [NTHR-1:0]  blk_q;
  logic [SEQW-1:0]  bseq_q [NTHR];

  logic [SEQW:0]    sq_bound;
  logic [NSLOT-1:0] sq_hit, free_now;
  logic [NTHR-1:0]  rel, blk_eff;
  logic             any_free;
  logic             flt_ok;
  logic [TW-1:0]    flt_tid;

  assign sq_bound = {1'b0, sq_seq} + {{SEQW{1'b0}}, sq_stall};
  assign flt_ok   = fault_vld && v_q[fault_slot];
  assign flt_tid  = tid_q[fault_slot];

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      sq_hit[i]   = sq_vld && v_q[i] && !sq_q[i] && (tid_q[i] == sq_tid) &&
                    ({1'b0, seq_q[i]} > sq_bound);
      free_now[i] = !v_q[i] || (sq_hit[i] && !pend_q[i]);
    end
    for (int t = 0; t < NTHR; t++) begin
      rel[t]     = sq_vld && (sq_tid == TW'(t)) && ({1'b0, bseq_q[t]} > sq_bound);
      blk_eff[t] = blk_q[t] && !rel[t] && !(trap_vld && trap_tid == TW'(t));
    end
  end

  always_comb begin
    any_free   = 1'b0;
    alloc_slot = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (free_now[i]) begin
        any_free   = 1'b1;
        alloc_slot = SW'(i);
      end
    end
  end

  assign alloc_blocked = alloc_req && blk_eff[alloc_tid];
  assign alloc_busy    = alloc_req && !any_free;
  assign alloc_gnt     = alloc_req && any_free && !blk_eff[alloc_tid];
  assign blk_o         = blk_q;

  always_comb begin
    find_hit  = 1'b0;
    find_slot = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (v_q[i] && tag_q[i] == find_tag && idx_q[i] == find_idx) begin
        find_hit  = 1'b1;
        find_slot = SW'(i);
      end
    end
  end

  assign find_pend  = find_hit && pend_q[find_slot];
  assign find_cmpl  = find_hit && cmpl_q[find_slot];
  assign find_stall = find_hit && stl_q[find_slot];
  assign find_sq    = find_hit && sq_q[find_slot];
  assign find_cmd   = find_hit ? cmd_q[find_slot] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0; pend_q <= '0; cmpl_q <= '0; stl_q <= '0; sq_q <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        tid_q[i] <= '0; seq_q[i] <= '0; tag_q[i] <= '0; idx_q[i] <= '0; cmd_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (sq_hit[i]) begin
          if (pend_q[i]) sq_q[i] <= 1'b1;
          else           v_q[i] <= 1'b0;
        end
        if (v_q[i] && issue_vld && issue_slot == SW'(i)) pend_q[i] <= 1'b1;
        if (v_q[i] && stall_vld && stall_slot == SW'(i)) stl_q[i] <= 1'b1;
        if (v_q[i] && fault_vld && fault_slot == SW'(i)) cmpl_q[i] <= 1'b1;
        if (v_q[i] && pend_q[i] && resp_vld && resp_slot == SW'(i)) begin
          pend_q[i] <= 1'b0;
          if (sq_q[i] || sq_hit[i]) begin
            v_q[i]  <= 1'b0;
            sq_q[i] <= 1'b0;
          end else begin
            cmpl_q[i] <= 1'b1;
            stl_q[i]  <= 1'b0;
          end
        end
        if (free_vld && free_slot == SW'(i)) begin
          v_q[i] <= 1'b0; pend_q[i] <= 1'b0; sq_q[i] <= 1'b0;
        end
        if (alloc_gnt && alloc_slot == SW'(i)) begin
          v_q[i] <= 1'b1; pend_q[i] <= 1'b0; cmpl_q[i] <= 1'b0;
          stl_q[i] <= 1'b0; sq_q[i] <= 1'b0;
          tid_q[i] <= alloc_tid; seq_q[i] <= alloc_seq;
          tag_q[i] <= alloc_tag; idx_q[i] <= alloc_idx; cmd_q[i] <= alloc_cmd;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q <= '0;
      for (int t = 0; t < NTHR; t++) bseq_q[t] <= '0;
    end else begin
      for (int t = 0; t < NTHR; t++) begin
        if (flt_ok && flt_tid == TW'(t)) begin
          blk_q[t]  <= 1'b1;
          bseq_q[t] <= seq_q[fault_slot];
        end else if (!blk_eff[t]) begin
          blk_q[t] <= 1'b0;
        end
      end
    end
  end

  p_refuse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt && !sq_vld && !trap_vld |-> !blk_q[alloc_tid]);

  p_fault_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flt_ok |=> blk_q[$past(flt_tid)] && cmpl_q[$past(fault_slot)]);

  p_sq_resp_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_vld && v_q[resp_slot] && pend_q[resp_slot] && sq_q[resp_slot]
    |=> !v_q[$past(resp_slot)]);

  p_trap_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_vld && !fault_vld |=> !blk_q[$past(trap_tid)]);

  p_busy_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_busy |-> &v_q);

  p_gnt_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt |=> v_q[$past(alloc_slot)]);

endmodule

// File: tb/sim_memreq_slot_table.sv
module sim_memreq_slot_table;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic alloc_req = 0, alloc_gnt, alloc_busy, alloc_blocked;
  logic [0:0] alloc_tid = 0, sq_tid = 0, trap_tid = 0;
  logic [15:0] alloc_seq = 0, sq_seq = 0;
  logic [7:0] alloc_tag = 0, find_tag = 0;
  logic [3:0] alloc_idx = 0, find_idx = 0;
  logic [2:0] alloc_cmd = 0, find_cmd;
  logic [1:0] alloc_slot, find_slot;
  logic [1:0] issue_slot = 0, stall_slot = 0, fault_slot = 0, resp_slot = 0, free_slot = 0;
  logic issue_vld = 0, stall_vld = 0, fault_vld = 0, resp_vld = 0, free_vld = 0;
  logic sq_vld = 0, sq_stall = 0, trap_vld = 0;
  logic find_hit, find_pend, find_cmpl, find_stall, find_sq;
  logic [1:0] blk_o;

  int n_chk = 0, n_err = 0;

  memreq_slot_table u0 (.*);

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    alloc_req = 0; issue_vld = 0; stall_vld = 0; fault_vld = 0;
    resp_vld = 0; free_vld = 0; sq_vld = 0; sq_stall = 0; trap_vld = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; step(); step(); rst_n = 1;
  endtask

  task automatic alloc(input int tid, input int seq, input int tag, input int idx);
    alloc_req = 1; alloc_tid = 1'(tid); alloc_seq = 16'(seq);
    alloc_tag = 8'(tag); alloc_idx = 4'(idx); alloc_cmd = 3'(tag);
  endtask

  task automatic look(input int tag, input int idx);
    find_tag = 8'(tag); find_idx = 4'(idx); #1;
  endtask

  task automatic squash(input int tid, input int seq, input bit stl);
    sq_vld = 1; sq_tid = 1'(tid); sq_seq = 16'(seq); sq_stall = stl;
  endtask

  task automatic t_reset();
    do_reset();
    look(0, 0); chk("R8 reset lookup", find_hit, 0);
    chk("R2 reset lock", blk_o, 0);
    alloc(0, 1, 1, 0); #1;
    chk("R9 reset busy", alloc_busy, 0);
    chk("R9 reset slot", alloc_slot, 0);
    step();
  endtask

  task automatic t_alloc();
    do_reset();
    for (int k = 0; k < 4; k++) begin
      alloc(k % 2, 10 + k, 20 + k, 0); #1;
      chk("R9 lowest free slot", alloc_slot, k);
      chk("R9 grant", alloc_gnt, 1);
      step();
    end
    alloc(0, 30, 40, 0); #1;
    chk("R9 busy when full", alloc_busy, 1);
    chk("R9 no grant when full", alloc_gnt, 0);
    step();
    look(22, 0); chk("R8 hit", find_hit, 1); chk("R8 hit slot", find_slot, 2);
    chk("R8 cmd", find_cmd, 22 % 8);
    look(22, 1); chk("R8 idx mismatch misses", find_hit, 0);
    free_vld = 1; free_slot = 1; step();
    look(21, 0); chk("R8 freed slot misses", find_hit, 0);
    alloc(1, 50, 60, 3); #1; chk("R9 reuse slot 1", alloc_slot, 1); step();
    look(60, 3); chk("R8 new entry found", find_slot, 1);
  endtask

  task automatic t_lock();
    do_reset();
    alloc(0, 5, 10, 0); step();
    fault_vld = 1; fault_slot = 0; step();
    chk("R2 lock set", blk_o[0], 1);
    look(10, 0); chk("R2 faulting slot complete", find_cmpl, 1);
    alloc(0, 6, 11, 0); #1;
    chk("R1 blocked flag", alloc_blocked, 1);
    chk("R1 no grant", alloc_gnt, 0);
    step();
    look(11, 0); chk("R1 nothing stored", find_hit, 0);
    alloc(1, 7, 12, 0); #1; chk("R1 other thread granted", alloc_gnt, 1); step();
    trap_vld = 1; trap_tid = 0; step();
    chk("R7 trap clears lock", blk_o[0], 0);
    alloc(0, 8, 13, 0); #1; chk("R7 alloc after trap", alloc_gnt, 1); step();
  endtask

  task automatic t_squash();
    do_reset();
    alloc(0, 10, 1, 0); step();
    alloc(0, 12, 2, 0); step();
    alloc(1, 15, 3, 0); step();
    alloc(0, 13, 4, 0); step();
    issue_vld = 1; issue_slot = 3; step();
    squash(0, 11, 0); step();
    look(2, 0); chk("R3 younger idle slot freed", find_hit, 0);
    look(4, 0); chk("R3 pending slot kept", find_hit, 1);
    chk("R3 pending slot squashed", find_sq, 1);
    look(1, 0); chk("R3 older slot kept", find_sq + 2 * find_hit, 2);
    look(3, 0); chk("R3 other thread kept", find_sq + 2 * find_hit, 2);
    squash(0, 5, 0); step();
    look(1, 0); chk("R3 older boundary frees", find_hit, 0);
    look(4, 0); chk("R3 already squashed skipped", find_pend + 2 * find_sq, 3);
    resp_vld = 1; resp_slot = 3; step();
    look(4, 0); chk("R6 squashed response frees", find_hit, 0);
    alloc(1, 40, 9, 2); step();
    look(9, 2); issue_vld = 1; issue_slot = find_slot;
    stall_vld = 1; stall_slot = find_slot; step();
    look(9, 2); chk("R6 pending and stalled", find_pend + 2 * find_stall, 3);
    resp_vld = 1; resp_slot = find_slot; step();
    look(9, 2);
    chk("R6 normal response", find_hit * 8 + find_cmpl * 4 + find_stall * 2 + find_pend, 12);
  endtask

  task automatic t_release();
    do_reset();
    alloc(1, 20, 5, 0); step();
    fault_vld = 1; fault_slot = 0; step();
    chk("R2 lock thread1", blk_o, 2);
    squash(1, 25, 0); step();
    chk("R4 lock kept when blocking seq not younger", blk_o[1], 1);
    squash(1, 19, 0); step();
    chk("R4 lock released", blk_o[1], 0);
    look(5, 0); chk("R3 faulting slot squashed away", find_hit, 0);
  endtask

  task automatic t_stall();
    do_reset();
    alloc(0, 30, 1, 0); step();
    alloc(0, 31, 2, 0); step();
    alloc(0, 32, 3, 0); step();
    squash(0, 30, 1); step();
    look(2, 0); chk("R5 S+1 survives", find_hit, 1);
    look(3, 0); chk("R5 beyond S+1 freed", find_hit, 0);
    squash(0, 30, 0); step();
    look(2, 0); chk("R3 plain squash frees S+1", find_hit, 0);
    look(1, 0); chk("R3 S itself kept", find_hit, 1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    for (int k = 0; k < 4; k++) begin alloc(0, 1 + k, 1 + k, 0); step(); end
    alloc(1, 9, 9, 0); #1; chk("R9 full before squash", alloc_busy, 1);
    squash(0, 2, 0); #1;
    chk("R10 squash frees for alloc", alloc_gnt, 1);
    chk("R10 lowest freed slot", alloc_slot, 2);
    step();
    look(9, 0); chk("R10 entry stored", find_slot, 2);
    look(4, 0); chk("R10 squashed slot gone", find_hit, 0);
    fault_vld = 1; fault_slot = 0; step();
    alloc(0, 3, 7, 0); squash(0, 0, 0); #1;
    chk("R10 lock released same cycle", alloc_gnt, 1);
    step();
  endtask

  initial begin
    #1_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_alloc();
    t_lock();
    t_squash();
    t_release();
    t_stall();
    t_same_cycle();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule